// File: doc/BRIEF.md
# Overcurrent Fault and Hiccup Sequencer

This block sits beside the PWM logic of a synchronous buck controller. It watches an overcurrent comparator during each high-side conduction interval. A qualified trip ends the current pulse at once. The result of every switching cycle moves a saturating 3-bit fault counter up or down. When the counter fills, the block declares a fault. The high-side gate is then held off, the low-side gate is held on, and the soft-start capacitor is discharged.

While the fault lasts, the same counter times the retry. Each completed discharge of the capacitor takes one count off. Between discharges the capacitor recharges to its regulation level. When the count returns to zero, the fault releases and a full soft-start begins. The capacitor and all comparators are outside the block and appear here as synchronous flags. A switching cycle is the interval during which `sw_high_i` is high. The cycle's verdict is taken on the clock edge where `sw_high_i` is first seen low.

States: `ST_OFF` (shutdown), `ST_SOFTSTART` (ramping, limiting on, counting off), `ST_RUN` (regulating, counting on), `ST_FLT_DISCH` (fault, capacitor discharging) and `ST_FLT_CHARGE` (fault, capacitor recharging). Transitions:
- Any state to `ST_OFF` when `en_i` is low.
- `ST_OFF` to `ST_SOFTSTART` when `en_i` is high.
- `ST_SOFTSTART` to `ST_RUN` when `ss_done_i` is high.
- `ST_RUN` to `ST_FLT_DISCH` when the count is 7.
- `ST_FLT_DISCH` to `ST_FLT_CHARGE` on `ss_empty_i` when the count is above 1.
- `ST_FLT_DISCH` to `ST_SOFTSTART` on `ss_empty_i` when the count is 1.
- `ST_FLT_CHARGE` to `ST_FLT_DISCH` on `ss_done_i`.

Top module: `ocp_hiccup_seq`

## Requirements
- R1: Reset, or `en_i` sampled low, puts the block in shutdown. From the next clock edge the count is 0, `fault_o` is 0, `ss_disch_o` is 0, `ls_on_o` is 0, and both `hs_off_o` and `ls_off_o` are 1. Once `en_i` is high, `hs_off_o` and `ls_off_o` return to 0.
- R2: `oc_trip_i` is ignored for the first BLANK_CYC (default 10) clock edges after `sw_high_i` is first sampled high. After that, while `sw_high_i` stays high, a high `oc_trip_i` drives `pwm_term_o` to 1 in the same cycle. `pwm_term_o` then stays at 1 until `sw_high_i` goes low.
- R3: In `ST_RUN`, at the end of each high interval the count rises by one if `pwm_term_o` fired in that interval, and falls by one otherwise.
- R4: The count saturates: it never goes below 0 or above 7, and it changes by at most one per clock while enabled.
- R5: One clock after the count reaches 7 in `ST_RUN`, the block enters fault with `fault_o`=1, `hs_off_o`=1, `ls_on_o`=1 and `ss_disch_o`=1.
- R6: In fault, each `ss_empty_i` pulse during discharge lowers the count by one. If the count is still nonzero, `ss_disch_o` drops to 0 while `fault_o` stays 1 (recharge). A `ss_done_i` pulse during recharge sets `ss_disch_o` back to 1.
- R7: The discharge that brings the count to 0 clears `fault_o`, `hs_off_o`, `ls_on_o` and `ss_disch_o` on that clock edge and starts a new soft-start. This gives six recharge/discharge rounds after the first discharge.
- R8: In `ST_SOFTSTART`, qualified trips still drive `pwm_term_o`, but the count does not change.
- R9: In fault, `sw_high_i` and `oc_trip_i` have no effect: `pwm_term_o` stays 0 and the count moves only on `ss_empty_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable; low means shutdown |
| sw_high_i | input | 1 | Switch node above the qualifying level (high-side conducting) |
| oc_trip_i | input | 1 | Overcurrent comparator output |
| ss_done_i | input | 1 | Soft-start capacitor at its regulation level |
| ss_empty_i | input | 1 | Soft-start capacitor fully discharged |
| pwm_term_o | output | 1 | Ends the present high-side pulse |
| fault_o | output | 1 | Fault declared (hiccup in progress) |
| hs_off_o | output | 1 | Forces the high-side gate off |
| ls_on_o | output | 1 | Forces the low-side gate on |
| ls_off_o | output | 1 | Forces the low-side gate off (shutdown) |
| ss_disch_o | output | 1 | Discharges the soft-start capacitor |
| oc_count_o | output | CNT_W | Fault counter value |

## Verification
The count is visible at the ports. A wrong increment, decrement or saturation therefore shows on `oc_count_o` one clock after the switching cycle that caused it. A wrong blanking count shows in the same cycle, as a `pwm_term_o` pulse that is early or missing. State errors show on the gate-force and discharge outputs within one clock of the triggering flag: a missed fault entry, an extra or missing hiccup round, or a counting soft-start. The retry sequence is walked round by round, and the expected count and discharge level are checked after every capacitor event.

// File: rtl/ocp_hiccup_pkg.sv
package ocp_hiccup_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_SOFTSTART,
        ST_RUN,
        ST_FLT_DISCH,
        ST_FLT_CHARGE
    } hic_state_e;

    typedef struct packed {
        logic hs_off;
        logic ls_on;
        logic ls_off;
        logic disch;
        logic fault;
    } gate_ctl_t;

endpackage

// File: rtl/ocp_blank_qual.sv
module ocp_blank_qual #(
    parameter int BLANK_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic sw_high_i,
    input  logic oc_trip_i,
    output logic term_o,
    output logic cycle_end_o,
    output logic trip_seen_o
);
    localparam int BW = $clog2(BLANK_CYC + 2);

    logic sw_prev;
    logic rise;
    logic blank_done;
    logic trip_now;
    logic trip_held;

    assign rise        = sw_high_i & ~sw_prev;
    assign cycle_end_o = ~sw_high_i & sw_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_prev <= 1'b0;
        end else begin
            sw_prev <= sw_high_i;
        end
    end

    generate
        if (BLANK_CYC == 0) begin : g_noblank
            assign blank_done = ~rise;
        end else begin : g_blank
            logic [BW-1:0] blank_cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    blank_cnt <= '0;
                end else if (rise) begin
                    blank_cnt <= BW'(BLANK_CYC);
                end else if (blank_cnt != '0) begin
                    blank_cnt <= blank_cnt - 1'b1;
                end
            end
            assign blank_done = ~rise & (blank_cnt == '0);
        end
    endgenerate

    assign trip_now = arm_i & sw_high_i & blank_done & oc_trip_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trip_held <= 1'b0;
        end else if (!sw_high_i || !arm_i) begin
            trip_held <= 1'b0;
        end else if (trip_now) begin
            trip_held <= 1'b1;
        end
    end

    assign term_o      = arm_i & (trip_now | trip_held);
    assign trip_seen_o = trip_held;

endmodule

// File: rtl/ocp_sat_counter.sv
module ocp_sat_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_max_o,
    output logic             is_one_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && !dec_i) begin
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (dec_i && !inc_i) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign at_max_o = (cnt_q == CNT_MAX);
    assign is_one_o = (cnt_q == CNT_ONE);

endmodule

// File: rtl/ocp_hiccup_fsm.sv
module ocp_hiccup_fsm
    import ocp_hiccup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       ss_done_i,
    input  logic       ss_empty_i,
    input  logic       cycle_end_i,
    input  logic       trip_seen_i,
    input  logic       cnt_at_max_i,
    input  logic       cnt_is_one_i,
    output logic       arm_o,
    output logic       cnt_inc_o,
    output logic       cnt_dec_o,
    output logic       cnt_clr_o,
    output gate_ctl_t  ctl_o
);
    hic_state_e state_q;
    hic_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_SOFTSTART;
                end
                ST_SOFTSTART: begin
                    if (ss_done_i) begin
                        state_d = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (cnt_at_max_i) begin
                        state_d = ST_FLT_DISCH;
                    end
                end
                ST_FLT_DISCH: begin
                    if (ss_empty_i) begin
                        state_d = cnt_is_one_i ? ST_SOFTSTART : ST_FLT_CHARGE;
                    end
                end
                ST_FLT_CHARGE: begin
                    if (ss_done_i) begin
                        state_d = ST_FLT_DISCH;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        ctl_o     = '0;
        arm_o     = 1'b0;
        cnt_inc_o = 1'b0;
        cnt_dec_o = 1'b0;
        cnt_clr_o = ~en_i;
        unique case (state_q)
            ST_OFF: begin
                ctl_o.hs_off = 1'b1;
                ctl_o.ls_off = 1'b1;
            end
            ST_SOFTSTART: begin
                arm_o = 1'b1;
            end
            ST_RUN: begin
                arm_o     = 1'b1;
                cnt_inc_o = cycle_end_i & trip_seen_i;
                cnt_dec_o = cycle_end_i & ~trip_seen_i;
            end
            ST_FLT_DISCH: begin
                ctl_o.fault  = 1'b1;
                ctl_o.hs_off = 1'b1;
                ctl_o.ls_on  = 1'b1;
                ctl_o.disch  = 1'b1;
                cnt_dec_o    = ss_empty_i;
            end
            ST_FLT_CHARGE: begin
                ctl_o.fault  = 1'b1;
                ctl_o.hs_off = 1'b1;
                ctl_o.ls_on  = 1'b1;
            end
            default: begin
                ctl_o.hs_off = 1'b1;
                ctl_o.ls_off = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ocp_hiccup_seq.sv
module ocp_hiccup_seq
    import ocp_hiccup_pkg::*;
#(
    parameter int CNT_W     = 3,
    parameter int BLANK_CYC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             sw_high_i,
    input  logic             oc_trip_i,
    input  logic             ss_done_i,
    input  logic             ss_empty_i,
    output logic             pwm_term_o,
    output logic             fault_o,
    output logic             hs_off_o,
    output logic             ls_on_o,
    output logic             ls_off_o,
    output logic             ss_disch_o,
    output logic [CNT_W-1:0] oc_count_o
);
    logic      arm;
    logic      cycle_end;
    logic      trip_seen;
    logic      cnt_inc;
    logic      cnt_dec;
    logic      cnt_clr;
    logic      cnt_at_max;
    logic      cnt_is_one;
    gate_ctl_t ctl;

    ocp_blank_qual #(.BLANK_CYC(BLANK_CYC)) blank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (arm),
        .sw_high_i   (sw_high_i),
        .oc_trip_i   (oc_trip_i),
        .term_o      (pwm_term_o),
        .cycle_end_o (cycle_end),
        .trip_seen_o (trip_seen)
    );

    ocp_sat_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (cnt_clr),
        .inc_i    (cnt_inc),
        .dec_i    (cnt_dec),
        .cnt_o    (oc_count_o),
        .at_max_o (cnt_at_max),
        .is_one_o (cnt_is_one)
    );

    ocp_hiccup_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .ss_done_i    (ss_done_i),
        .ss_empty_i   (ss_empty_i),
        .cycle_end_i  (cycle_end),
        .trip_seen_i  (trip_seen),
        .cnt_at_max_i (cnt_at_max),
        .cnt_is_one_i (cnt_is_one),
        .arm_o        (arm),
        .cnt_inc_o    (cnt_inc),
        .cnt_dec_o    (cnt_dec),
        .cnt_clr_o    (cnt_clr),
        .ctl_o        (ctl)
    );

    assign fault_o    = ctl.fault;
    assign hs_off_o   = ctl.hs_off;
    assign ls_on_o    = ctl.ls_on;
    assign ls_off_o   = ctl.ls_off;
    assign ss_disch_o = ctl.disch;

endmodule

// File: rtl/ocp_hiccup_chk.sv
module ocp_hiccup_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             sw_high_i,
    input logic             pwm_term_o,
    input logic             fault_o,
    input logic             hs_off_o,
    input logic             ls_on_o,
    input logic             ls_off_o,
    input logic [CNT_W-1:0] oc_count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    AST_SHUTDOWN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (oc_count_o == '0 && hs_off_o && ls_off_o && !fault_o && !ls_on_o)) // R1
        else $error("shutdown state wrong");

    AST_BLANK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_high_i) |-> !pwm_term_o) // R2
        else $error("trip accepted in blanking");

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i)) |-> (oc_count_o == $past(oc_count_o)
            || oc_count_o == $past(oc_count_o) + 1'b1
            || oc_count_o + 1'b1 == $past(oc_count_o))) // R4
        else $error("count jumped");

    AST_FAULT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && oc_count_o == CNT_MAX && !fault_o) |=> fault_o) // R5
        else $error("fault not declared");

    AST_FAULT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (hs_off_o && ls_on_o && !pwm_term_o && !ls_off_o)) // R9
        else $error("fault drive wrong");

    AST_FAULT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_o) |-> oc_count_o == '0) // R7
        else $error("fault released with nonzero count");

endmodule

bind ocp_hiccup_seq ocp_hiccup_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .sw_high_i  (sw_high_i),
    .pwm_term_o (pwm_term_o),
    .fault_o    (fault_o),
    .hs_off_o   (hs_off_o),
    .ls_on_o    (ls_on_o),
    .ls_off_o   (ls_off_o),
    .oc_count_o (oc_count_o)
);

// File: tb/ocp_hiccup_seq_tb_top.sv
module ocp_hiccup_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic       sw_high_i = 1'b0;
    logic       oc_trip_i = 1'b0;
    logic       ss_done_i = 1'b0;
    logic       ss_empty_i = 1'b0;
    logic       pwm_term_o, fault_o, hs_off_o, ls_on_o, ls_off_o, ss_disch_o;
    logic [2:0] oc_count_o;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    ocp_hiccup_seq #(.CNT_W(3), .BLANK_CYC(10)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .sw_high_i(sw_high_i),
        .oc_trip_i(oc_trip_i), .ss_done_i(ss_done_i), .ss_empty_i(ss_empty_i),
        .pwm_term_o(pwm_term_o), .fault_o(fault_o), .hs_off_o(hs_off_o),
        .ls_on_o(ls_on_o), .ls_off_o(ls_off_o), .ss_disch_o(ss_disch_o),
        .oc_count_o(oc_count_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // one high-side interval; returns whether pwm_term_o was seen
    task automatic pulse(input int len, input bit oc, output bit seen);
        seen = 1'b0;
        @(negedge clk);
        sw_high_i = 1'b1;
        oc_trip_i = oc;
        #1;
        if (pwm_term_o) seen = 1'b1;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            #1;
            if (pwm_term_o) seen = 1'b1;
        end
        sw_high_i = 1'b0;
        oc_trip_i = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 count in reset", oc_count_o, 0);
        chk("R1 hs_off in reset", hs_off_o, 1);
        chk("R1 ls_off in reset", ls_off_o, 1);
        chk("R1 fault in reset", fault_o, 0);
        en_i = 1'b1;
        tick();
        tick();
        chk("R1 gates released", {hs_off_o, ls_off_o, ls_on_o}, 0);
    endtask

    task automatic t_softstart();
        bit s;
        pulse(20, 1'b1, s);
        chk("R8 term during soft start", s, 1);
        chk("R8 count frozen", oc_count_o, 0);
        chk("R2 term drops after interval", pwm_term_o, 0);
        ss_done_i = 1'b1;
        tick();
    endtask

    task automatic t_counting();
        bit s;
        pulse(20, 1'b1, s);
        chk("R3 trip term", s, 1);
        chk("R3 count up", oc_count_o, 1);
        pulse(20, 1'b1, s);
        chk("R3 count up again", oc_count_o, 2);
        pulse(20, 1'b0, s);
        chk("R3 clean no term", s, 0);
        chk("R3 count down", oc_count_o, 1);
        pulse(8, 1'b1, s);
        chk("R2 blanked trip ignored", s, 0);
        chk("R2 blanked counts as clean", oc_count_o, 0);
        pulse(12, 1'b1, s);
        chk("R2 trip right after blanking", s, 1);
        pulse(20, 1'b0, s);
        pulse(20, 1'b0, s);
        chk("R4 floor at zero", oc_count_o, 0);
    endtask

    task automatic t_fault();
        bit s;
        for (int k = 1; k <= 7; k++) begin
            pulse(20, 1'b1, s);
            chk("R3 climbing count", oc_count_o, k);
        end
        tick();
        chk("R5 fault", fault_o, 1);
        chk("R5 hs_off", hs_off_o, 1);
        chk("R5 ls_on", ls_on_o, 1);
        chk("R5 discharge", ss_disch_o, 1);
        chk("R4 ceiling at seven", oc_count_o, 7);
        ss_done_i = 1'b0;
        pulse(20, 1'b1, s);
        chk("R9 no term in fault", s, 0);
        chk("R9 count unchanged in fault", oc_count_o, 7);
        for (int k = 6; k >= 1; k--) begin
            ss_empty_i = 1'b1;
            tick();
            ss_empty_i = 1'b0;
            chk("R6 count after discharge", oc_count_o, k);
            chk("R6 recharge phase", {fault_o, ss_disch_o}, 2);
            ss_done_i = 1'b1;
            tick();
            ss_done_i = 1'b0;
            chk("R6 discharge again", ss_disch_o, 1);
        end
        ss_empty_i = 1'b1;
        tick();
        ss_empty_i = 1'b0;
        chk("R7 count zero", oc_count_o, 0);
        chk("R7 fault cleared", fault_o, 0);
        chk("R7 gates released", {hs_off_o, ls_on_o, ss_disch_o}, 0);
        pulse(20, 1'b1, s);
        chk("R8 restart soft start no count", oc_count_o, 0);
    endtask

    task automatic t_shutdown();
        bit s;
        ss_done_i = 1'b1;
        tick();
        pulse(20, 1'b1, s);
        pulse(20, 1'b1, s);
        chk("R3 count before shutdown", oc_count_o, 2);
        en_i = 1'b0;
        tick();
        chk("R1 shutdown clears count", oc_count_o, 0);
        chk("R1 shutdown gates", {hs_off_o, ls_off_o, ls_on_o}, 6);
        pulse(20, 1'b1, s);
        chk("R1 no term in shutdown", s, 0);
        chk("R1 count held at zero", oc_count_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_softstart();
        t_counting();
        t_fault();
        t_shutdown();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule